// File: doc/BRIEF.md
# Addressed Packet Header Decoder

This block sits behind a first-word-fall-through FIFO that delivers 16-bit words. It reads a fixed five-word header at the front of each packet and passes the payload that follows to one of sixteen logical output channels. The header is never passed on. The first header word names a destination board and a channel. The last header word gives the payload length. The three words in between are not used on receive.

Packets addressed to a different board are discarded whole. The block still reads exactly the advertised number of payload words, so the next packet's header is found at the right place. A saturating counter, visible on a status output, records how many packets were rejected. Channel 0 carries loopback traffic and channel 1 carries configuration traffic. The other channels have no assigned use but are routed in the same way. The board identity is a static input.

The output channels share one data bus, and each channel has its own valid and ready. The FIFO word is presented on the bus without a register, so a payload word moves in the same cycle it is read. When the selected channel is not ready, the block stops reading.

Top module: `pkt_route_demux`

## Requirements
- R1: In header word 0, bits 15:4 hold the 12-bit destination ID and bits 3:0 hold the channel number. Each payload word of an accepted packet appears on `ch_data` with only `ch_valid[channel]` high. Every other valid bit stays low.
- R2: Header words 1, 2 and 3 may hold any value, and that value has no effect on routing, acceptance or the payload that is delivered.
- R3: Header word 4 is the payload length in words (0 to 65535). For an accepted packet, exactly that many words are delivered, in FIFO order. No header word is ever delivered.
- R4: A packet whose ID differs from `local_id` produces no valid on any channel. Its length field is still honoured: exactly that many payload words are read and thrown away, and the next packet is decoded normally.
- R5: `drop_count` is 0 after reset. It rises by exactly one for each rejected packet, including a rejected packet of zero length. It holds at its maximum value instead of wrapping.
- R6: An accepted packet of zero length delivers nothing, and the next word read is treated as the next packet's header word 0.
- R7: While the selected channel holds its ready low during payload, `in_rd` stays low. `ch_valid` and `ch_data` hold the pending word, and no word is lost or repeated.
- R8: `in_rd` is high only when `in_empty` is low. A word is consumed in each cycle in which `in_rd` is high, and no data moves while the FIFO is empty.
- R9: While reset is low, `in_rd` and all of `ch_valid` are low and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_id | input | 12 | Board identity this decoder accepts |
| in_data | input | 16 | Head word of the FIFO, valid while `in_empty` is low |
| in_empty | input | 1 | FIFO has no word to offer |
| in_rd | output | 1 | Consume the head word this cycle |
| ch_data | output | 16 | Payload word shared by all channels |
| ch_valid | output | 16 | Per-channel valid, at most one bit high |
| ch_ready | input | 16 | Per-channel ready |
| drop_count | output | 16 | Saturating count of rejected packets |

## Verification
`in_rd`, `ch_valid` and `ch_data` follow from the inputs and the decode state within the same cycle. The bench therefore drives at the falling edge and samples these outputs at the next falling edge, before any rising edge has moved the state. The decode state and `drop_count` change on the rising edge that consumes a word, so the count for a rejected packet is due one edge after its length word is read. The bench reads the count only after the FIFO model has drained. Delivered words are logged at each rising edge where valid and ready are both high, and the log is compared with the sent packets once the FIFO is empty.

// File: rtl/pkt_route_pkg.sv
// Shared types for the packet routing demultiplexer.
package pkt_route_pkg;
    // Decode phase: reading header words, or moving payload words.
    typedef enum logic {
        ST_HDR = 1'b0,
        ST_PAY = 1'b1
    } rx_phase_e;
endpackage

// File: rtl/pkt_hdr_fsm.sv
// Header walker for the packet routing demultiplexer.
// Counts header words, captures the destination ID and channel from the
// first header word and the payload length from the last header word,
// then tracks the payload words still to go.
// Assumes: HDR_WORDS >= 2, the ID and channel word comes first, the length
// word comes last, and `take` is high only when a word is actually consumed.
module pkt_hdr_fsm
    import pkt_route_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CH_W      = 4,
    parameter int HDR_WORDS = 5,
    localparam int ID_W     = DATA_W - CH_W,
    localparam int IDX_W    = $clog2(HDR_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   local_id,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    output logic              in_pay,
    output logic              drop_pkt,
    output logic [CH_W-1:0]   chan,
    output logic              reject
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);

    rx_phase_e         phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ID_W-1:0]   id_q;
    logic [CH_W-1:0]   chan_q;
    logic [DATA_W-1:0] rem_q;
    logic              drop_q;
    logic              at_len;
    logic              mismatch;

    // Decode of the last header word and of the address check.
    always_comb begin
        at_len   = (phase_q == ST_HDR) && (idx_q == LAST_IDX);
        mismatch = (id_q != local_id);
    end

    // Header word counting, field capture and payload countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_HDR;
            idx_q   <= '0;
            id_q    <= '0;
            chan_q  <= '0;
            rem_q   <= '0;
            drop_q  <= 1'b0;
        end else if (take) begin
            if (phase_q == ST_HDR) begin
                if (idx_q == '0) begin
                    id_q   <= in_data[DATA_W-1:CH_W];
                    chan_q <= in_data[CH_W-1:0];
                end
                if (at_len) begin
                    idx_q  <= '0;
                    rem_q  <= in_data;
                    drop_q <= mismatch;
                    if (in_data != '0) begin
                        phase_q <= ST_PAY;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else begin
                rem_q <= rem_q - 1'b1;
                if (rem_q == DATA_W'(1)) begin
                    phase_q <= ST_HDR;
                end
            end
        end
    end

    // Outputs toward the demux and the reject counter.
    always_comb begin
        in_pay   = (phase_q == ST_PAY);
        drop_pkt = drop_q;
        chan     = chan_q;
        reject   = take && at_len && mismatch;
    end

    AST_PAY_REM_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_PAY) |-> (rem_q != '0)); // R3
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q <= LAST_IDX)); // R3
    AST_PAY_ENDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (phase_q == ST_PAY) && (rem_q == DATA_W'(1))) |=> (phase_q == ST_HDR) && (idx_q == '0)); // R6
endmodule

// File: rtl/pkt_ch_demux.sv
// Channel fan-out for the packet routing demultiplexer.
// Raises the valid of the selected channel while a deliverable payload word
// is at the FIFO head, and returns that channel's ready.
// Assumes: NCH is a power of two matching the channel field width.
module pkt_ch_demux #(
    parameter int NCH  = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            deliver,
    input  logic            word_avail,
    input  logic [CH_W-1:0] chan,
    input  logic [NCH-1:0]  ch_ready,
    output logic [NCH-1:0]  ch_valid,
    output logic            sel_ready
);
    // Per-channel valid decode, one comparator per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_comb begin
            ch_valid[g] = deliver && word_avail && (chan == CH_W'(g));
        end
    end

    // Ready of the channel currently addressed.
    always_comb begin
        sel_ready = ch_ready[chan];
    end

    AST_ONEHOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid)); // R1
endmodule

// File: rtl/pkt_drop_cnt.sv
// Saturating counter of rejected packets.
// Assumes: `bump` is a single-cycle pulse per rejected packet.
module pkt_drop_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count up on each reject, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (bump && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_NEVER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt >= $past(cnt)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1)); // R5
endmodule

// File: rtl/pkt_route_demux.sv
// Packet routing demultiplexer top.
// Reads a header-prefixed word stream from a first-word-fall-through FIFO,
// drops packets addressed elsewhere, strips the header and steers payload
// to one of NCH valid/ready channels over a shared data bus.
// Assumes: in_data is stable while in_empty is low and in_rd is low;
// local_id is static during traffic.
module pkt_route_demux #(
    parameter int DATA_W    = 16,
    parameter int NCH       = 16,
    parameter int HDR_WORDS = 5,
    parameter int CNT_W     = 16,
    localparam int CH_W     = $clog2(NCH),
    localparam int ID_W     = DATA_W - CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   local_id,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_empty,
    output logic              in_rd,
    output logic [DATA_W-1:0] ch_data,
    output logic [NCH-1:0]    ch_valid,
    input  logic [NCH-1:0]    ch_ready,
    output logic [CNT_W-1:0]  drop_count
);
    logic            in_pay;
    logic            drop_pkt;
    logic [CH_W-1:0] chan;
    logic            reject;
    logic            sel_ready;
    logic            deliver;

    // Read strobe: headers and discarded payload flow freely, kept payload waits for ready.
    always_comb begin
        deliver = in_pay && !drop_pkt;
        in_rd   = rst_n && !in_empty && (!in_pay || drop_pkt || sel_ready);
        ch_data = in_data;
    end

    pkt_hdr_fsm #(
        .DATA_W    (DATA_W),
        .CH_W      (CH_W),
        .HDR_WORDS (HDR_WORDS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .local_id (local_id),
        .in_data  (in_data),
        .take     (in_rd),
        .in_pay   (in_pay),
        .drop_pkt (drop_pkt),
        .chan     (chan),
        .reject   (reject)
    );

    pkt_ch_demux #(
        .NCH (NCH)
    ) u_demux (
        .clk        (clk),
        .rst_n      (rst_n),
        .deliver    (deliver),
        .word_avail (!in_empty),
        .chan       (chan),
        .ch_ready   (ch_ready),
        .ch_valid   (ch_valid),
        .sel_ready  (sel_ready)
    );

    pkt_drop_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (reject),
        .cnt   (drop_count)
    );

    AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> !in_empty); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_valid & ~ch_ready) != '0) |-> !in_rd); // R7
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pay && drop_pkt) |-> (ch_valid == '0)); // R4
    AST_HDR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_pay |-> (ch_valid == '0)); // R3
endmodule

// File: tb/sim_pkt_route_demux.sv
module sim_pkt_route_demux;
    localparam int TB_CNT_W = 3;
    localparam logic [11:0] MY_ID = 12'h3A7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data;
    logic        in_empty;
    logic        in_rd;
    logic [15:0] ch_data;
    logic [15:0] ch_valid;
    logic [15:0] rdy = 16'hFFFF;
    logic [TB_CNT_W-1:0] drop_count;
    logic        hold_empty = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [15:0] fifo [0:511];
    int wp = 0;
    int rp;

    logic [3:0]  log_ch [0:511];
    logic [15:0] log_d  [0:511];
    int nlog;

    always #2 clk = ~clk;

    pkt_route_demux #(.CNT_W(TB_CNT_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_id   (MY_ID),
        .in_data    (in_data),
        .in_empty   (in_empty),
        .in_rd      (in_rd),
        .ch_data    (ch_data),
        .ch_valid   (ch_valid),
        .ch_ready   (rdy),
        .drop_count (drop_count)
    );

    assign in_empty = hold_empty || (rp == wp);
    assign in_data  = fifo[rp[8:0]];

    function automatic logic [3:0] idx_of(input logic [15:0] v);
        logic [3:0] r = '0;
        for (int i = 0; i < 16; i++) if (v[i]) r = 4'(i);
        return r;
    endfunction

    // FIFO read side model.
    always @(posedge clk) begin
        if (!rst_n) rp <= 0;
        else if (in_rd) rp <= rp + 1;
    end

    // Sink: log each delivered word.
    always @(posedge clk) begin
        if (!rst_n) nlog <= 0;
        else if ((ch_valid & rdy) != 16'h0) begin
            log_ch[nlog] <= idx_of(ch_valid);
            log_d[nlog]  <= ch_data;
            nlog <= nlog + 1;
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        fifo[wp[8:0]] = w;
        wp = wp + 1;
    endtask

    task automatic send_pkt(input logic [11:0] id, input logic [3:0] ch, input int len,
                            input logic [15:0] base, input logic [15:0] r);
        push({id, ch});
        push(r);
        push(~r);
        push(r ^ 16'h5a5a);
        push(16'(len));
        for (int k = 0; k < len; k++) push(base + 16'(k));
    endtask

    task automatic drain();
        while (rp != wp) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_words(input int start, input logic [3:0] ch, input int len,
                               input logic [15:0] base, input string tag);
        chk(nlog == start + len, {tag, " count"}, nlog - start, len);
        for (int k = 0; k < len; k++) begin
            chk(log_ch[start+k] == ch, {tag, " chan"}, int'(log_ch[start+k]), int'(ch));
            chk(log_d[start+k] == base + 16'(k), {tag, " data"}, int'(log_d[start+k]), int'(base + 16'(k)));
        end
    endtask

    // R9: idle outputs while held in reset.
    task automatic t_reset();
        push(16'h1234);
        @(negedge clk);
        chk(in_rd == 1'b0, "R9 in_rd", int'(in_rd), 0);
        chk(ch_valid == 16'h0, "R9 ch_valid", int'(ch_valid), 0);
        chk(drop_count == '0, "R9 drop_count", int'(drop_count), 0);
        wp = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_rd == 1'b0, "R8 no read while empty", int'(in_rd), 0);
    endtask

    // R1 R2 R3: accepted packet routed to its channel.
    task automatic t_route(input logic [3:0] ch, input int len, input logic [15:0] base,
                           input logic [15:0] r);
        int s = nlog;
        send_pkt(MY_ID, ch, len, base, r);
        drain();
        check_words(s, ch, len, base, "R1 R2 R3 route");
    endtask

    // R4 R5: wrong ID dropped, framing kept.
    task automatic t_reject();
        int s = nlog;
        int c0 = int'(drop_count);
        send_pkt(MY_ID ^ 12'h001, 4'd2, 4, 16'hBEEF, 16'h0);
        send_pkt(MY_ID, 4'd2, 2, 16'h7000, 16'h1111);
        drain();
        check_words(s, 4'd2, 2, 16'h7000, "R4 after reject");
        chk(int'(drop_count) == c0 + 1, "R5 one increment", int'(drop_count), c0 + 1);
    endtask

    // R6: zero-length accepted packet.
    task automatic t_zero();
        int s = nlog;
        send_pkt(MY_ID, 4'd3, 0, 16'h0, 16'hFFFF);
        send_pkt(MY_ID, 4'd3, 2, 16'h9000, 16'h0);
        drain();
        check_words(s, 4'd3, 2, 16'h9000, "R6 zero len");
    endtask

    // R7: back-pressure stalls without loss.
    task automatic t_stall();
        int s = nlog;
        int r0 = rp;
        rdy = 16'hFFDF;
        send_pkt(MY_ID, 4'd5, 4, 16'hA100, 16'h2222);
        repeat (12) @(negedge clk);
        chk(rp == r0 + 5, "R7 header only consumed", rp - r0, 5);
        chk(in_rd == 1'b0, "R7 in_rd low", int'(in_rd), 0);
        chk(ch_valid == 16'h0020, "R7 valid held", int'(ch_valid), 16'h0020);
        chk(ch_data == 16'hA100, "R7 data held", int'(ch_data), 16'hA100);
        rdy = 16'hFFFF;
        drain();
        check_words(s, 4'd5, 4, 16'hA100, "R7 after stall");
    endtask

    // R8: no movement while FIFO empty.
    task automatic t_gap();
        int s = nlog;
        int r0 = rp;
        hold_empty = 1'b1;
        send_pkt(MY_ID, 4'd7, 3, 16'hC000, 16'h3333);
        repeat (4) @(negedge clk);
        chk(in_rd == 1'b0, "R8 in_rd while empty", int'(in_rd), 0);
        chk(ch_valid == 16'h0, "R8 no valid while empty", int'(ch_valid), 0);
        chk(rp == r0, "R8 nothing consumed", rp - r0, 0);
        hold_empty = 1'b0;
        drain();
        check_words(s, 4'd7, 3, 16'hC000, "R8 after gap");
    endtask

    // R5: zero-length rejects counted and saturating.
    task automatic t_sat();
        int s = nlog;
        for (int i = 0; i < 9; i++) send_pkt(12'h000, 4'(i), 0, 16'h0, 16'h0);
        drain();
        chk(drop_count == 3'd7, "R5 saturates", int'(drop_count), 7);
        chk(nlog == s, "R4 rejects silent", nlog - s, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_route(4'd1, 3, 16'h0100, 16'h0000);
        t_route(4'd0, 1, 16'h0200, 16'hFFFF);
        t_route(4'd15, 6, 16'h0300, {12'h3A6, 4'hF});
        t_route(4'd9, 2, 16'h0400, {MY_ID, 4'h1});
        t_reject();
        t_zero();
        t_stall();
        t_gap();
        t_sat();
        summary();
    end
endmodule